// File: doc/BRIEF.md
# Chipset Control Register with Write-Once Lock and Shutdown Handling

This block is a small memory-mapped configuration register for a chipset. A single-cycle write strobe and a single-cycle read strobe reach it. It holds four control fields:

- an alternate-access enable;
- a shutdown-policy select;
- an I/O port route select;
- a lock bit that can be set once and cannot be cleared.

The lock guards a second register that holds a 1-bit swap flag and a 2-bit boot-destination field. Once the lock is set, writes to that register are dropped until the next system reset.

The block also turns an incoming one-cycle shutdown message into a platform action. The policy field picks the action:

- with the policy clear, the processor init line is pulsed low for a fixed number of clocks;
- with the policy set, the message is treated like a full-reset request, and the platform reset line is held low for a longer fixed time.

One shared down-counter times both pulses. The reset pulse has priority over the init pulse.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: After reset, every field reads 0, `rdata_o` is 0, and both `init_n_o` and `prst_n_o` are high.
- R2: Address 0 is the control word: bit 0 = lock, bit 1 = route, bit 2 = shutdown policy, bit 3 = alternate-access enable. A write to address 0 updates route, policy and alternate-access from the write data on the next clock.
- R3: `alt_access_o` always equals the alternate-access field (control bit 3).
- R4: The lock field can only go from 0 to 1. A write with bit 0 = 1 sets it. A write with bit 0 = 0 leaves it unchanged until reset.
- R5: Address 1 is the protected word: bit 0 = swap, bits 2:1 = boot destination. A write there updates both fields only if the lock was 0 before that clock edge. Otherwise the write is discarded and both fields keep their values.
- R6: With policy 0, a shutdown message drives `init_n_o` low for exactly INIT_CYCLES (16) consecutive clocks, starting the clock after the message is sampled.
- R7: With policy 1, a shutdown message drives `prst_n_o` low for exactly RST_CYCLES (64) consecutive clocks, starting the clock after the message is sampled.
- R8: A shutdown message that arrives while a pulse is running is ignored, with one exception. A message with policy 1 during an init pulse ends the init pulse at once and starts a full reset pulse. `init_n_o` and `prst_n_o` are never low together.
- R9: A read returns the addressed word on `rdata_o` one clock after the read strobe. Reserved bits and addresses other than 0 and 1 read as 0. `rdata_o` holds its value while no read strobe is given.
- R10: `route_pci_o` always equals the route field: 0 routes to LPC, 1 to PCI.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| wr_en_i | input | 1 | Single-cycle write strobe |
| rd_en_i | input | 1 | Single-cycle read strobe |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid one clock after the read strobe |
| shut_msg_i | input | 1 | One-cycle shutdown message strobe |
| alt_access_o | output | 1 | Alternate-access enable flag |
| route_pci_o | output | 1 | Port route select (1 = PCI, 0 = LPC) |
| swap_o | output | 1 | Protected swap flag |
| boot_dest_o | output | 2 | Protected boot-destination field |
| lock_o | output | 1 | Lock state |
| init_n_o | output | 1 | Active-low processor init pulse |
| prst_n_o | output | 1 | Active-low platform reset |

## Verification
The assertions take for granted three things about the inputs:

- the shutdown message is a one-cycle strobe;
- the read and write strobes are each one cycle wide;
- reset is released synchronously to the clock.

The pulse-length checks also assume that nothing outside the block holds the counter. The stimulus drives every input on the falling clock edge. It raises the shutdown strobe for one cycle at a time, and only in directed sequences. The random phase covers all four addresses and arbitrary data, with the shutdown input held low.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

  // Register addresses
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned PROT_ADDR = 1;

  // Control word bit positions
  localparam int unsigned CTRL_LOCK_BIT   = 0;
  localparam int unsigned CTRL_ROUTE_BIT  = 1;
  localparam int unsigned CTRL_POLICY_BIT = 2;
  localparam int unsigned CTRL_ALT_BIT    = 3;

  // Protected word bit positions
  localparam int unsigned PROT_SWAP_BIT = 0;
  localparam int unsigned PROT_BOOT_LSB = 1;

  typedef enum logic [1:0] {
    SD_IDLE = 2'd0,
    SD_INIT = 2'd1,
    SD_RST  = 2'd2
  } sd_mode_e;

  typedef struct packed {
    logic       alt;
    logic       policy;
    logic       route;
    logic       lock;
  } ctrl_fields_t;

  typedef struct packed {
    logic [1:0] boot;
    logic       swap;
  } prot_fields_t;

endpackage

// File: rtl/cfg_lock_regs.sv
module cfg_lock_regs
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_fields_t      ctrl_o,
  output prot_fields_t      prot_o
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_PROT = ADDR_W'(PROT_ADDR);

  ctrl_fields_t      ctrl_q, ctrl_d;
  prot_fields_t      prot_q, prot_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              ctrl_we, prot_we;

  assign ctrl_we = wr_en_i && (addr_i == A_CTRL);
  assign prot_we = wr_en_i && (addr_i == A_PROT) && !ctrl_q.lock;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.lock   = ctrl_q.lock | wdata_i[CTRL_LOCK_BIT];
      ctrl_d.route  = wdata_i[CTRL_ROUTE_BIT];
      ctrl_d.policy = wdata_i[CTRL_POLICY_BIT];
      ctrl_d.alt    = wdata_i[CTRL_ALT_BIT];
    end
  end

  always_comb begin
    prot_d = prot_q;
    if (prot_we) begin
      prot_d.swap = wdata_i[PROT_SWAP_BIT];
      prot_d.boot = wdata_i[PROT_BOOT_LSB +: 2];
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en_i) begin
      rdata_d = '0;
      if (addr_i == A_CTRL) begin
        rdata_d[CTRL_LOCK_BIT]   = ctrl_q.lock;
        rdata_d[CTRL_ROUTE_BIT]  = ctrl_q.route;
        rdata_d[CTRL_POLICY_BIT] = ctrl_q.policy;
        rdata_d[CTRL_ALT_BIT]    = ctrl_q.alt;
      end else if (addr_i == A_PROT) begin
        rdata_d[PROT_SWAP_BIT]      = prot_q.swap;
        rdata_d[PROT_BOOT_LSB +: 2] = prot_q.boot;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      prot_q  <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      prot_q  <= prot_d;
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;
  assign ctrl_o  = ctrl_q;
  assign prot_o  = prot_q;

  assert_lock_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> ctrl_q.lock);

  assert_prot_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.lock |=> $stable(prot_q));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && addr_i != A_CTRL && addr_i != A_PROT) |=> (rdata_o == '0));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rdata_o));

endmodule

// File: rtl/cfg_lock_shutdown.sv
module cfg_lock_shutdown
  import cfg_lock_pkg::*;
#(
  parameter int unsigned INIT_CYCLES = 16,
  parameter int unsigned RST_CYCLES  = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shut_msg_i,
  input  logic policy_i,
  output logic init_n_o,
  output logic prst_n_o
);

  localparam int unsigned MAX_CYC = (RST_CYCLES > INIT_CYCLES) ? RST_CYCLES : INIT_CYCLES;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] INIT_LOAD = CNT_W'(INIT_CYCLES - 1);
  localparam logic [CNT_W-1:0] RST_LOAD  = CNT_W'(RST_CYCLES - 1);

  sd_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    unique case (mode_q)
      SD_IDLE: begin
        if (shut_msg_i) begin
          mode_d = policy_i ? SD_RST : SD_INIT;
          cnt_d  = policy_i ? RST_LOAD : INIT_LOAD;
        end
      end
      SD_INIT: begin
        if (shut_msg_i && policy_i) begin
          mode_d = SD_RST;
          cnt_d  = RST_LOAD;
        end else if (cnt_q == '0) begin
          mode_d = SD_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SD_RST: begin
        if (cnt_q == '0) begin
          mode_d = SD_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        mode_d = SD_IDLE;
        cnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= SD_IDLE;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign init_n_o = (mode_q != SD_INIT);
  assign prst_n_o = (mode_q != SD_RST);

  // Checker: run lengths of each low pulse
  logic [CNT_W:0] init_run_q, rst_run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_run_q <= '0;
      rst_run_q  <= '0;
    end else begin
      init_run_q <= init_n_o ? '0 : init_run_q + 1'b1;
      rst_run_q  <= prst_n_o ? '0 : rst_run_q + 1'b1;
    end
  end

  assert_init_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_run_q <= (CNT_W+1)'(INIT_CYCLES));

  assert_rst_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_run_q <= (CNT_W+1)'(RST_CYCLES));

  assert_init_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(init_n_o) |-> $past(shut_msg_i && !policy_i));

  assert_rst_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prst_n_o) |-> $past(shut_msg_i && policy_i));

  assert_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    init_n_o || prst_n_o);

endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
  import cfg_lock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned INIT_CYCLES = 16,
  parameter int unsigned RST_CYCLES  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              shut_msg_i,
  output logic              alt_access_o,
  output logic              route_pci_o,
  output logic              swap_o,
  output logic [1:0]        boot_dest_o,
  output logic              lock_o,
  output logic              init_n_o,
  output logic              prst_n_o
);

  ctrl_fields_t ctrl;
  prot_fields_t prot;

  cfg_lock_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctrl_o  (ctrl),
    .prot_o  (prot)
  );

  cfg_lock_shutdown #(
    .INIT_CYCLES (INIT_CYCLES),
    .RST_CYCLES  (RST_CYCLES)
  ) u_shutdown (
    .clk        (clk),
    .rst_n      (rst_n),
    .shut_msg_i (shut_msg_i),
    .policy_i   (ctrl.policy),
    .init_n_o   (init_n_o),
    .prst_n_o   (prst_n_o)
  );

  assign alt_access_o = ctrl.alt;
  assign route_pci_o  = ctrl.route;
  assign swap_o       = prot.swap;
  assign boot_dest_o  = prot.boot;
  assign lock_o       = ctrl.lock;

endmodule

// File: tb/cfg_lock_ctrl_tb.sv
module cfg_lock_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam int INIT_CYC = 16;
  localparam int RST_CYC = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en, rd_en, shut;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] rdata;
  logic              alt_o, route_o, swap_o, lock_o, init_n, prst_n;
  logic [1:0]        boot_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model
  logic m_lock, m_route, m_pol, m_alt, m_swap;
  logic [1:0] m_boot;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_lock_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .INIT_CYCLES(INIT_CYC), .RST_CYCLES(RST_CYC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .shut_msg_i(shut), .alt_access_o(alt_o),
    .route_pci_o(route_o), .swap_o(swap_o), .boot_dest_o(boot_o), .lock_o(lock_o),
    .init_n_o(init_n), .prst_n_o(prst_n)
  );

  function automatic logic [DATA_W-1:0] exp_read(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] v = '0;
    if (a == 0) v[3:0] = {m_alt, m_pol, m_route, m_lock};
    else if (a == 1) v[2:0] = {m_boot, m_swap};
    return v;
  endfunction

  function automatic void model_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    if (a == 0) begin
      m_lock  = m_lock | d[0];
      m_route = d[1];
      m_pol   = d[2];
      m_alt   = d[3];
    end else if (a == 1 && !m_lock) begin
      m_swap = d[0];
      m_boot = d[2:1];
    end
  endfunction

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_outputs();
    chk("R3 alt_access_o", {31'd0, alt_o}, {31'd0, m_alt});
    chk("R10 route_pci_o", {31'd0, route_o}, {31'd0, m_route});
    chk("R4 lock_o", {31'd0, lock_o}, {31'd0, m_lock});
    chk("R5 prot outputs", {29'd0, boot_o, swap_o}, {29'd0, m_boot, m_swap});
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    chk_outputs();
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rdata, exp_read(a));
  endtask

  // Starts a shutdown pulse; optionally a second message at sample sec_at
  // and a policy=1 control write at sample wr_at. Counts low samples.
  task automatic run_shut(input int sec_at, input int wr_at, output int ni, output int nr);
    ni = 0; nr = 0;
    @(negedge clk);
    shut = 1'b1;
    for (int n = 1; n < 300; n++) begin
      @(negedge clk);
      if (!init_n) ni++;
      if (!prst_n) nr++;
      shut  = (n == sec_at);
      wr_en = (n == wr_at);
      if (n == wr_at) begin
        addr = 0; wdata = 32'h4;
        model_write(0, 32'h4);
      end
      if (init_n && prst_n && !shut) break;
    end
    shut = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int ni, nr;
    logic [ADDR_W-1:0] ra;
    logic [DATA_W-1:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; wr_en = 0; rd_en = 0; shut = 0; addr = '0; wdata = '0;
    {m_lock, m_route, m_pol, m_alt, m_swap, m_boot} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 rdata after reset", rdata, '0);
    chk("R1 init_n high", {31'd0, init_n}, 32'd1);
    chk("R1 prst_n high", {31'd0, prst_n}, 32'd1);
    chk_outputs();
    do_read(0, "R1 control reads 0");
    do_read(1, "R1 protected reads 0");

    // R2/R3/R10: control fields without lock
    do_write(0, 32'hFFFF_FFFA);
    do_read(0, "R2 control layout");
    do_write(0, 32'h0000_0000);
    do_read(0, "R2 control cleared");

    // R9: reserved address and hold
    do_read(2, "R9 reserved address reads 0");
    do_write(1, 32'h7);
    do_read(1, "R9 protected read");
    repeat (3) @(negedge clk);
    chk("R9 rdata holds without read", rdata, exp_read(1));

    // R6: init pulse length
    run_shut(0, 0, ni, nr);
    chk("R6 init pulse length", ni, INIT_CYC);
    chk("R6 no reset pulse", nr, 0);
    // R8: second message during init ignored
    run_shut(5, 0, ni, nr);
    chk("R8 init not retriggered", ni, INIT_CYC);
    chk("R8 no reset on ignored msg", nr, 0);
    // R8: policy switched to 1 mid-init preempts into reset
    run_shut(5, 2, ni, nr);
    chk("R8 init cut by reset", ni, 5);
    chk("R8 reset after preempt", nr, RST_CYC);
    // R7: reset pulse length; second message during reset ignored
    run_shut(10, 0, ni, nr);
    chk("R7 reset pulse length", nr, RST_CYC);
    chk("R7 no init under policy 1", ni, 0);
    chk_outputs();

    // Random phase before lock (keep lock bit clear)
    for (int i = 0; i < 150; i++) begin
      ra = ADDR_W'($urandom_range(0, 3));
      rd = $urandom();
      if (ra == 0) rd[0] = 1'b0;
      if ($urandom_range(0, 1) == 1) do_write(ra, rd);
      else do_read(ra, "R9 random read");
    end

    // R4/R5: set lock, then protected write next cycle is discarded
    do_write(1, 32'h5);
    @(negedge clk);
    wr_en = 1'b1; addr = 0; wdata = 32'h1;
    @(negedge clk);
    addr = 1; wdata = 32'h2;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(0, 32'h1);
    model_write(1, 32'h2);
    do_read(1, "R5 write right after lock dropped");
    chk("R5 boot frozen", {30'd0, boot_o}, 32'd2);
    do_write(0, 32'h0);
    do_read(0, "R4 lock survives write of 0");

    // Random phase after lock
    for (int i = 0; i < 150; i++) begin
      ra = ADDR_W'($urandom_range(0, 3));
      rd = $urandom();
      if ($urandom_range(0, 1) == 1) do_write(ra, rd);
      else do_read(ra, "R5 random read while locked");
    end

    // R1: reset clears the lock
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    {m_lock, m_route, m_pol, m_alt, m_swap, m_boot} = '0;
    @(negedge clk);
    chk_outputs();
    do_write(1, 32'h3);
    do_read(1, "R1 protected writable after reset");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule